// File: doc/BRIEF.md
# Converter Serial Port Sequencer

This block is the digital half of a delta-sigma converter's serial interface. It runs a three-state cycle: a timed conversion, a quiet wait in which the result is held, and a read phase. In the read phase a host, clocking SCK, pulls the 16-bit result out MSB first on SDO. On the same clock it shifts a 4-bit setup word in on SDI. The internal logic runs on a system clock `clk` and treats `csN`, `sck` and `sdi` as inputs that change between its edges. It finds SCK edges by comparing each input with its value one cycle earlier.

The conversion itself is a behavioural stand-in. Its length is `CONV_CYCLES` clock cycles in the default fast mode and `SLOW_FACTOR` times that in the calibrated mode. When it ends, the block pulses `convDone` and latches `convData` as the new result. The setup word can change the speed mode and ask for the reference to be powered down after the next conversion. The host wakes the reference again by pulling chip select low. An active-low `porN` clears every register and starts a conversion.

Top module: `adcSerialPort`

## Requirements
- R1: While and right after `porN` is low, the block is converting (`convBusy`=1), `sdo` is 1, `refOn` is 1, the speed mode is fast and sleep is off.
- R2: One conversion keeps `convBusy` high for exactly `CONV_CYCLES` clock edges in fast mode (speed bit 0) and `SLOW_FACTOR*CONV_CYCLES` in slow mode (speed bit 1).
- R3: While a conversion runs, `sdo` is 1 even if `csN` is low. The read phase begins on the first clock edge at which `csN` is low and no conversion is running.
- R4: Once the read phase begins, and before any SCK edge, `sdo` shows result bit 15.
- R5: Each SCK falling edge moves `sdo` to the next lower result bit, so the 16 bits sampled before each SCK rise form the result MSB first.
- R6: The 16th SCK falling edge of a read ends the read phase and starts a new conversion on the next clock edge.
- R7: `csN` going high during the read phase aborts the read and starts a new conversion. A setup word with fewer than 4 captured bits changes nothing.
- R8: SDI is sampled on SCK rising edges, and the first four bits, in order, form the setup word. The word is applied only if bit one is 1 and bit two is 0. Bit three then sets the speed mode and bit four sets sleep. Any other prefix leaves both settings unchanged.
- R9: With sleep set, `refOn` stays 1 through the next conversion and drops to 0 when it ends. A later `csN` low that starts a read sets `refOn` back to 1.
- R10: SDI bits after the fourth rising edge of a read are ignored.
- R11: `sdoEn` is 1 exactly while `csN` is low.
- R12: Each conversion pulses `convDone` for exactly one cycle. A read returns the `convData` value latched at the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Setup data from the host |
| convData | input | DATA_W | Result from the converter stub |
| sdo | output | 1 | Serial result data |
| sdoEn | output | 1 | Drive enable for `sdo` (0 models high impedance) |
| refOn | output | 1 | Reference power enable |
| convBusy | output | 1 | High while a conversion runs |
| convDone | output | 1 | One-cycle pulse when a conversion ends |

## Verification
Full reads are run with setup words chosen to separate the prefix check from the payload bits: a valid word, two words with wrong prefixes, and a valid prefix with a harmful pattern placed only in the ignored tail. Each outcome is read back at the ports through the measured length of the next conversion and the level of `refOn`. Aborts come after three and after five SCK bits, which shows whether a setup word is committed at its fourth bit. A read that begins while a conversion is still running checks that `sdo` stays high and that the first bit appears without latency. Every read is compared with the value the bench's stub presented at the matching `convDone` pulse.

// File: rtl/adcPortPkg.sv
package adcPortPkg;

  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    ST_CONVERT = 2'd0,
    ST_IDLE    = 2'd1,
    ST_READ    = 2'd2
  } portState_e;

  typedef struct packed {
    logic converting;
    logic convEnd;
    logic startRead;
    logic reading;
    logic shiftOut;
    logic sampleIn;
  } portStrobe_s;

endpackage

// File: rtl/adcPortCtrl.sv
module adcPortCtrl
  import adcPortPkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        csN,
  input  logic        sck,
  input  logic        countAtLimit,
  input  logic        lastBit,
  output portStrobe_s strb,
  output logic        readActive,
  output logic        convBusy
);

  portState_e state, stateNext;
  logic sckPrev;
  logic sckRise, sckFall;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state   <= ST_CONVERT;
      sckPrev <= 1'b0;
    end else begin
      state   <= stateNext;
      sckPrev <= sck;
    end
  end

  assign sckRise = sck & ~sckPrev;
  assign sckFall = ~sck & sckPrev;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_CONVERT: begin
        strb.converting = 1'b1;
        if (countAtLimit) begin
          strb.convEnd = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (!csN) begin
          strb.startRead = 1'b1;
          stateNext      = ST_READ;
        end
      end
      ST_READ: begin
        strb.reading = 1'b1;
        if (csN) begin
          stateNext = ST_CONVERT;
        end else begin
          strb.shiftOut = sckFall;
          strb.sampleIn = sckRise;
          if (sckFall && lastBit) stateNext = ST_CONVERT;
        end
      end
      default: stateNext = ST_CONVERT;
    endcase
  end

  assign readActive = (state == ST_READ);
  assign convBusy   = (state == ST_CONVERT);

endmodule

// File: rtl/adcPortDatapath.sv
module adcPortDatapath
  import adcPortPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SLOW_FACTOR = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  portStrobe_s       strb,
  input  logic              sdi,
  input  logic [DATA_W-1:0] convData,
  output logic              sdo,
  output logic              refOn,
  output logic              countAtLimit,
  output logic              lastBit
);

  localparam int CNT_W = $clog2(SLOW_FACTOR * CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int RXC_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_FACTOR * CONV_CYCLES - 1);
  localparam logic [BIT_W-1:0] LAST_IDX  = BIT_W'(DATA_W - 1);
  localparam logic [RXC_W-1:0] RX_FINAL  = RXC_W'(CFG_W - 1);
  localparam logic [RXC_W-1:0] RX_FULL   = RXC_W'(CFG_W);

  logic [CNT_W-1:0]  convCount;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] shiftReg;
  logic [BIT_W-1:0]  bitIdx;
  logic [RXC_W-1:0]  rxCount;
  logic [CFG_W-2:0]  rxBits;
  logic [CFG_W-1:0]  rxWord;
  logic              cfgSpeed;
  logic              cfgSleep;
  logic              wordValid;

  // conversion timer
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 convCount <= '0;
    else if (!strb.converting) convCount <= '0;
    else                       convCount <= convCount + 1'b1;
  end

  assign countAtLimit = (convCount == (cfgSpeed ? SLOW_LAST : FAST_LAST));

  // result latch and output shifter
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      resultReg <= '0;
      shiftReg  <= '0;
      bitIdx    <= '0;
    end else begin
      if (strb.convEnd) resultReg <= convData;
      if (strb.startRead) begin
        shiftReg <= resultReg;
        bitIdx   <= '0;
      end else if (strb.shiftOut) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
        bitIdx   <= bitIdx + 1'b1;
      end
    end
  end

  assign lastBit = (bitIdx == LAST_IDX);
  assign sdo     = strb.reading ? shiftReg[DATA_W-1] : 1'b1;

  // setup word capture
  assign rxWord    = {rxBits, sdi};
  assign wordValid = rxWord[CFG_W-1] & ~rxWord[CFG_W-2];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rxCount  <= '0;
      rxBits   <= '0;
      cfgSpeed <= 1'b0;
      cfgSleep <= 1'b0;
    end else if (strb.startRead) begin
      rxCount <= '0;
      rxBits  <= '0;
    end else if (strb.sampleIn && rxCount != RX_FULL) begin
      rxBits  <= rxWord[CFG_W-2:0];
      rxCount <= rxCount + 1'b1;
      if (rxCount == RX_FINAL && wordValid) begin
        cfgSpeed <= rxWord[1];
        cfgSleep <= rxWord[0];
      end
    end
  end

  // reference power: sleep is deferred to the end of a conversion
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               refOn <= 1'b1;
    else if (strb.startRead) refOn <= 1'b1;
    else if (strb.convEnd)   refOn <= ~cfgSleep;
  end

endmodule

// File: rtl/adcSerialPort.sv
module adcSerialPort
  import adcPortPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SLOW_FACTOR = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] convData,
  output logic              sdo,
  output logic              sdoEn,
  output logic              refOn,
  output logic              convBusy,
  output logic              convDone
);

  portStrobe_s strb;
  logic countAtLimit;
  logic lastBit;
  logic readActive;

  adcPortCtrl u_ctrl (
    .clk          (clk),
    .porN         (porN),
    .csN          (csN),
    .sck          (sck),
    .countAtLimit (countAtLimit),
    .lastBit      (lastBit),
    .strb         (strb),
    .readActive   (readActive),
    .convBusy     (convBusy)
  );

  adcPortDatapath #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES),
    .SLOW_FACTOR (SLOW_FACTOR)
  ) u_dp (
    .clk          (clk),
    .porN         (porN),
    .strb         (strb),
    .sdi          (sdi),
    .convData     (convData),
    .sdo          (sdo),
    .refOn        (refOn),
    .countAtLimit (countAtLimit),
    .lastBit      (lastBit)
  );

  assign convDone = strb.convEnd;
  assign sdoEn    = ~csN;

endmodule

// File: rtl/adcSerialPortChecker.sv
module adcSerialPortChecker (
  input logic clk,
  input logic porN,
  input logic csN,
  input logic sdo,
  input logic refOn,
  input logic convBusy,
  input logic convDone,
  input logic readActive
);

  // R3: no data leaves the port while converting
  a_r3_sdo_high_busy: assert property (@(posedge clk) disable iff (!porN)
    convBusy |-> sdo);

  // R12: one pulse per conversion
  a_r12_done_single: assert property (@(posedge clk) disable iff (!porN)
    convDone |=> !convDone);

  // R12: a pulse only ends a running conversion
  a_r12_done_in_conv: assert property (@(posedge clk) disable iff (!porN)
    convDone |-> convBusy);

  // R2: a conversion only stops through its done pulse
  a_r2_end_by_done: assert property (@(posedge clk) disable iff (!porN)
    $fell(convBusy) |-> $past(convDone));

  // R9: the reference only powers down at a conversion end
  a_r9_sleep_at_end: assert property (@(posedge clk) disable iff (!porN)
    $fell(refOn) |-> $past(convDone));

  // R7: chip select high during a read starts a conversion
  a_r7_abort: assert property (@(posedge clk) disable iff (!porN)
    (readActive && csN) |=> convBusy);

endmodule

bind adcSerialPort adcSerialPortChecker u_chk (
  .clk        (clk),
  .porN       (porN),
  .csN        (csN),
  .sdo        (sdo),
  .refOn      (refOn),
  .convBusy   (convBusy),
  .convDone   (convDone),
  .readActive (readActive)
);

// File: tb/adcSerialPort_bench.sv
module adcSerialPort_bench;

  localparam int DW = 16;
  localparam int CC = 12;
  localparam int SF = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic porN, csN, sck, sdi;
  logic [DW-1:0] convData;
  logic sdo, sdoEn, refOn, convBusy, convDone;

  int checks = 0;
  int errors = 0;

  adcSerialPort #(.DATA_W(DW), .CONV_CYCLES(CC), .SLOW_FACTOR(SF)) u_adcSerialPort (
    .clk(clk), .porN(porN), .csN(csN), .sck(sck), .sdi(sdi),
    .convData(convData), .sdo(sdo), .sdoEn(sdoEn), .refOn(refOn),
    .convBusy(convBusy), .convDone(convDone)
  );

  function automatic logic [DW-1:0] pat(int k);
    return DW'(k * 15261 + 977) ^ 16'hA55A;
  endfunction

  // converter stub and bench-side measurement
  int convIdx = 0;
  int doneCount = 0;
  int run = 0;
  int lastLen = 0;
  logic [DW-1:0] lastLatched = '0;
  assign convData = pat(convIdx);

  always @(posedge clk) begin
    if (!porN) begin
      run <= 0;
    end else begin
      if (convDone) begin
        lastLatched <= convData;
        convIdx     <= convIdx + 1;
        doneCount   <= doneCount + 1;
      end
      if (convBusy) run <= run + 1;
      else if (run != 0) begin
        lastLen <= run;
        run     <= 0;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (convBusy) @(negedge clk);
    @(negedge clk);
  endtask

  // nbits < 16 aborts by raising csN after that many SCK cycles
  task automatic readFrame(input logic [3:0] cfg, input int nbits,
                           input logic [11:0] tail, output logic [DW-1:0] got);
    got = '0;
    @(negedge clk) csN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < DW; i++) begin
      if (i >= nbits) break;
      got[DW-1-i] = sdo;
      sck = 1'b1;
      sdi = (i < 4) ? cfg[3-i] : tail[11-(i-4)];
      @(negedge clk) sck = 1'b0;
      @(negedge clk);
    end
    csN = 1'b1;
    sdi = 1'b0;
    if (nbits < DW) @(negedge clk);
  endtask

  logic [DW-1:0] got;
  logic [DW-1:0] expWord;
  int doneBefore;

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    porN = 1'b0; csN = 1'b1; sck = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 32'(convBusy), 1);
    check("R1 sdo in reset", 32'(sdo), 1);
    check("R1 refOn in reset", 32'(refOn), 1);
    check("R11 sdoEn cs high", 32'(sdoEn), 0);
    porN = 1'b1;
    waitIdle();
    check("R2 first conversion fast", 32'(lastLen), 32'(CC));
    check("R1 ref kept on", 32'(refOn), 1);

    // plain read, no programming
    expWord = lastLatched;
    readFrame(4'b0000, 16, 12'h000, got);
    check("R4 R5 full word", 32'(got), 32'(expWord));
    check("R4 first bit", 32'(got[DW-1]), 32'(expWord[DW-1]));
    check("R6 conversion after 16th fall", 32'(convBusy), 1);

    // cs low during conversion
    @(negedge clk) csN = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 sdo high while busy", 32'(sdo), 1);
    check("R11 sdoEn cs low", 32'(sdoEn), 1);
    doneBefore = doneCount;
    while (convBusy) @(negedge clk);
    @(negedge clk);
    check("R4 first bit immediately", 32'(sdo), 32'(pat(1) >> 15));
    check("R12 single done pulse", 32'(doneCount - doneBefore), 1);
    check("R2 fast length", 32'(lastLen), 32'(CC));
    expWord = lastLatched;
    readFrame(4'b1010, 16, 12'h000, got);
    check("R12 latest result", 32'(got), 32'(expWord));
    waitIdle();
    check("R8 valid word sets slow", 32'(lastLen), 32'(SF * CC));

    // wrong prefixes leave slow mode
    readFrame(4'b1100, 16, 12'h000, got);
    waitIdle();
    check("R8 prefix 11 ignored", 32'(lastLen), 32'(SF * CC));
    readFrame(4'b0000, 16, 12'h000, got);
    waitIdle();
    check("R8 prefix 00 ignored", 32'(lastLen), 32'(SF * CC));
    readFrame(4'b1000, 16, 12'h000, got);
    waitIdle();
    check("R8 back to fast", 32'(lastLen), 32'(CC));

    // abort before the word completes
    readFrame(4'b1011, 3, 12'h000, got);
    check("R7 abort starts conversion", 32'(convBusy), 1);
    waitIdle();
    check("R7 short word no speed change", 32'(lastLen), 32'(CC));
    check("R7 short word no sleep", 32'(refOn), 1);
    expWord = lastLatched;
    readFrame(4'b1010, 5, 12'h000, got);
    check("R7 partial read bits", 32'(got[DW-1 -: 5]), 32'(expWord[DW-1 -: 5]));
    waitIdle();
    check("R7 word kept after 4 bits", 32'(lastLen), 32'(SF * CC));

    // deferred sleep and wake
    readFrame(4'b1001, 16, 12'h000, got);
    repeat (2) @(negedge clk);
    check("R9 ref on during conversion", 32'(refOn), 1);
    waitIdle();
    check("R9 ref asleep after conversion", 32'(refOn), 0);
    check("R8 fast after 1001", 32'(lastLen), 32'(CC));
    @(negedge clk) csN = 1'b0;
    @(negedge clk);
    check("R9 wake on cs low", 32'(refOn), 1);
    expWord = lastLatched;
    readFrame(4'b1000, 16, 12'h000, got);
    check("R12 read after wake", 32'(got), 32'(expWord));
    waitIdle();
    check("R9 sleep cleared", 32'(refOn), 1);

    // trailing bits ignored
    readFrame(4'b0000, 16, 12'b0000_0000_1011, got);
    waitIdle();
    check("R10 tail speed ignored", 32'(lastLen), 32'(CC));
    check("R10 tail sleep ignored", 32'(refOn), 1);
    readFrame(4'b1000, 16, 12'b1011_1011_1011, got);
    waitIdle();
    check("R10 tail after valid word", 32'(lastLen), 32'(CC));
    check("R10 tail after valid sleep", 32'(refOn), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule